// File: doc/BRIEF.md
# Configuration Stream Loader

This block brings up a downstream programmable device from a byte stream. After a start request it checks that a configuration store is present. If the store is there, it steps through a fixed control sequence. The local bus reset is pulsed first, then the reload control, then the device program pin. The block then polls the device's init-ready status. Once the device reports ready, the block consumes bytes from a valid/ready source. It throws away everything before a two-byte sync marker, pairs the remaining bytes into 16-bit words and writes them to the device port one word at a time.

After each word the init status is read back. A low status abandons the attempt. An attempt also fails when the device never reports ready, when the stream holds no marker, or when the stream ends with half a word. A failed attempt is retried from the reset pulse, up to a fixed number of attempts. The source replays the stream from its first byte each time the program pin is driven high. A complete load finishes with one more reset-and-reload sequence and a one-cycle done pulse. Running out of attempts leaves a fail flag set until the next start request.

Top module: `cfg_stream_loader`

## Requirements
- R1: If `store_present` is low in the cycle after an accepted start, `fail` is raised without any pulse on `bus_reset`, `reload` or `prog`. `fail` then stays high until the next start request and drops in the cycle after that request.
- R2: Every attempt drives `bus_reset` high, then `reload` high, then `prog` high. Each pulse lasts exactly SETTLE_CYC cycles and sits between low holds of SETTLE_CYC cycles. At most one of the three is high in any cycle.
- R3: After the program pulse, `dev_init` is sampled once every POLL_GAP_CYC cycles, up to POLL_MAX times. If it is never seen high, the next attempt's `bus_reset` rises exactly SETTLE_CYC + POLL_MAX*POLL_GAP_CYC + 1 cycles after the last high cycle of `prog`.
- R4: Bytes are discarded until a byte 0xFF is directly followed by 0x20. The first word written is 0xFF20.
- R5: Each later word is built from two consecutive accepted bytes, with the first byte in bits 15:8 and the second in bits 7:0.
- R6: `wr_en` is a single-cycle strobe. It rises exactly GAP_CYC cycles after the clock edge that accepted the word's last byte.
- R7: `dev_init` is sampled in the cycle after every `wr_en`. If it is low, the attempt is abandoned and no further word is written in that attempt.
- R8: At most MAX_TRY attempts are made, and each one begins with its own program pulse. A run whose attempts all fail ends with `fail` high.
- R9: After the word holding the stream's last byte is written and `dev_init` reads high, the block issues one more `bus_reset` and `reload` pulse with no `prog` pulse. It then raises `done` for exactly one cycle.
- R10: A stream that ends before the sync marker is found, or ends with an unpaired byte after it, fails the attempt.
- R11: `s_ready` is high only while the block is hunting for the marker or collecting word bytes. No byte is consumed during the control sequence or when the store is absent.
- R12: A start request is accepted only while the block is idle or failed. A request during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request (one cycle) |
| store_present | input | 1 | Configuration store present flag |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_last | input | 1 | Marks the final byte of the stream |
| s_ready | output | 1 | Block accepts a byte this cycle |
| dev_init | input | 1 | Device init-ready status |
| bus_reset | output | 1 | Local bus reset control |
| reload | output | 1 | Reload control |
| prog | output | 1 | Device program pin |
| wr_en | output | 1 | Word write strobe to device port |
| wr_data | output | 16 | Word written to device port |
| done | output | 1 | One-cycle load-complete pulse |
| fail | output | 1 | Sticky load-failed flag |

## Verification
Two events can land on one accepted byte. The end of the stream can arrive on the 0x20 that completes the sync marker, and it can arrive on the first byte of a new pair. The first case is provoked with a stream whose final two bytes are 0xFF, 0x20. It is judged correct when exactly one word, 0xFF20, is written and the run ends in `done` after a single attempt. The second case uses a stream with an odd byte count after the marker. It is judged correct when every attempt writes only the complete pairs and the run ends in `fail` after MAX_TRY program pulses. A start request that falls inside a run is also driven, and the reset pulse counts confirm it changed nothing.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RST_HI,
    ST_RST_LO,
    ST_RLD_LO1,
    ST_RLD_HI,
    ST_RLD_LO2,
    ST_PRG_HI,
    ST_PRG_LO,
    ST_POLL,
    ST_HUNT,
    ST_LOAD_HI,
    ST_LOAD_LO,
    ST_GAP,
    ST_WRITE,
    ST_VERIFY,
    ST_DONE,
    ST_FAIL
  } cfl_state_e;

  typedef enum logic [1:0] {
    PH_NONE,
    PH_HUNT,
    PH_HI,
    PH_LO
  } cfl_phase_e;

endpackage

// File: rtl/cfl_interval_timer.sv
module cfl_interval_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load) begin
      cnt_n = load_val;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign zero = (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R2

endmodule

// File: rtl/cfl_step_counter.sv
module cfl_step_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr) begin
      cnt_n = '0;
    end else if (inc) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/cfl_word_packer.sv
module cfl_word_packer
  import cfl_pkg::*;
#(
  parameter logic [7:0] SYNC_HI = 8'hFF,
  parameter logic [7:0] SYNC_LO = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  cfl_phase_e       phase,
  input  logic [7:0]       din,
  output logic             sync_hit,
  output logic [15:0]      word
);

  logic       prev_hi_q, prev_hi_n;
  logic [7:0] hi_q, hi_n;
  logic [7:0] lo_q, lo_n;

  assign sync_hit = (phase == PH_HUNT) && prev_hi_q && (din == SYNC_LO);

  always_comb begin
    prev_hi_n = prev_hi_q;
    hi_n      = hi_q;
    lo_n      = lo_q;
    if (clear) begin
      prev_hi_n = 1'b0;
    end else if (take) begin
      case (phase)
        PH_HUNT: begin
          prev_hi_n = (din == SYNC_HI);
          if (sync_hit) begin
            hi_n = SYNC_HI;
            lo_n = din;
          end
        end
        PH_HI:   hi_n = din;
        PH_LO:   lo_n = din;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hi_q <= 1'b0;
      hi_q      <= '0;
      lo_q      <= '0;
    end else begin
      prev_hi_q <= prev_hi_n;
      hi_q      <= hi_n;
      lo_q      <= lo_n;
    end
  end

  assign word = {hi_q, lo_q};

  AST_SYNC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sync_hit && !clear) |=> (word == {SYNC_HI, SYNC_LO})); // R4

  AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear && phase == PH_HI) |=> (word[15:8] == $past(din))); // R5

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfl_pkg::*;
#(
  parameter int SETTLE_CYC   = 16,
  parameter int POLL_GAP_CYC = 8,
  parameter int POLL_MAX     = 50,
  parameter int GAP_CYC      = 4,
  parameter int MAX_TRY      = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        store_present,
  input  logic [7:0]  s_data,
  input  logic        s_valid,
  input  logic        s_last,
  output logic        s_ready,
  input  logic        dev_init,
  output logic        bus_reset,
  output logic        reload,
  output logic        prog,
  output logic        wr_en,
  output logic [15:0] wr_data,
  output logic        done,
  output logic        fail
);

  localparam int MAX_A   = (SETTLE_CYC > POLL_GAP_CYC) ? SETTLE_CYC : POLL_GAP_CYC;
  localparam int TMR_MAX = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int POLL_W  = $clog2(POLL_MAX + 1);
  localparam int TRY_W   = $clog2(MAX_TRY + 1);

  localparam logic [TMR_W-1:0]  SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0]  POLL_LD   = TMR_W'(POLL_GAP_CYC - 1);
  localparam logic [TMR_W-1:0]  GAP_LD    = TMR_W'(GAP_CYC - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);
  localparam logic [TRY_W-1:0]  TRY_LAST  = TRY_W'(MAX_TRY - 1);

  cfl_state_e state_q, state_n;
  logic       last_q, last_n;
  logic       fin_q, fin_n;

  logic              tmr_load;
  logic              tmr_reload;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic              poll_clr, poll_inc;
  logic [POLL_W-1:0] poll_cnt;
  logic              try_clr, try_inc;
  logic [TRY_W-1:0]  try_cnt;
  logic              abort;
  logic              take;
  logic              pk_clear;
  logic              sync_hit;
  cfl_phase_e        phase;
  logic [15:0]       word;

  // stream side
  always_comb begin
    case (state_q)
      ST_HUNT:    phase = PH_HUNT;
      ST_LOAD_HI: phase = PH_HI;
      ST_LOAD_LO: phase = PH_LO;
      default:    phase = PH_NONE;
    endcase
  end

  assign s_ready  = (phase != PH_NONE);
  assign take     = s_ready && s_valid;
  assign pk_clear = (state_q == ST_PRG_HI);

  // next-state logic
  always_comb begin
    state_n    = state_q;
    last_n     = last_q;
    fin_n      = fin_q;
    tmr_reload = 1'b0;
    poll_clr   = 1'b0;
    poll_inc   = 1'b0;
    try_clr    = 1'b0;
    try_inc    = 1'b0;
    abort      = 1'b0;

    case (state_q)
      ST_IDLE, ST_FAIL: begin
        if (start) begin
          state_n = ST_CHECK;
          try_clr = 1'b1;
          fin_n   = 1'b0;
          last_n  = 1'b0;
        end
      end
      ST_CHECK:   state_n = store_present ? ST_RST_HI : ST_FAIL;
      ST_RST_HI:  if (tmr_zero) state_n = ST_RST_LO;
      ST_RST_LO:  if (tmr_zero) state_n = ST_RLD_LO1;
      ST_RLD_LO1: if (tmr_zero) state_n = ST_RLD_HI;
      ST_RLD_HI:  if (tmr_zero) state_n = ST_RLD_LO2;
      ST_RLD_LO2: if (tmr_zero) state_n = fin_q ? ST_DONE : ST_PRG_HI;
      ST_PRG_HI:  if (tmr_zero) state_n = ST_PRG_LO;
      ST_PRG_LO: begin
        if (tmr_zero) begin
          state_n  = ST_POLL;
          poll_clr = 1'b1;
        end
      end
      ST_POLL: begin
        if (tmr_zero) begin
          if (dev_init) begin
            state_n = ST_HUNT;
          end else if (poll_cnt == POLL_LAST) begin
            abort = 1'b1;
          end else begin
            poll_inc   = 1'b1;
            tmr_reload = 1'b1;
          end
        end
      end
      ST_HUNT: begin
        if (take) begin
          if (sync_hit) begin
            last_n  = s_last;
            state_n = ST_GAP;
          end else if (s_last) begin
            abort = 1'b1;
          end
        end
      end
      ST_LOAD_HI: begin
        if (take) begin
          if (s_last) begin
            abort = 1'b1;
          end else begin
            state_n = ST_LOAD_LO;
          end
        end
      end
      ST_LOAD_LO: begin
        if (take) begin
          last_n  = s_last;
          state_n = ST_GAP;
        end
      end
      ST_GAP:   if (tmr_zero) state_n = ST_WRITE;
      ST_WRITE: state_n = ST_VERIFY;
      ST_VERIFY: begin
        if (!dev_init) begin
          abort = 1'b1;
        end else if (last_q) begin
          fin_n   = 1'b1;
          state_n = ST_RST_HI;
        end else begin
          state_n = ST_LOAD_HI;
        end
      end
      ST_DONE:  state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase

    if (abort) begin
      if (try_cnt == TRY_LAST) begin
        state_n = ST_FAIL;
      end else begin
        try_inc = 1'b1;
        state_n = ST_RST_HI;
      end
    end
  end

  // interval selection for the state being entered
  always_comb begin
    case (state_n)
      ST_GAP:  tmr_val = GAP_LD;
      ST_POLL: tmr_val = POLL_LD;
      default: tmr_val = SETTLE_LD;
    endcase
  end

  assign tmr_load = (state_n != state_q) || tmr_reload;

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      last_q  <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      last_q  <= last_n;
      fin_q   <= fin_n;
    end
  end

  cfl_interval_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  cfl_step_counter #(.W(POLL_W)) u_poll_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (poll_clr),
    .inc   (poll_inc),
    .cnt   (poll_cnt)
  );

  cfl_step_counter #(.W(TRY_W)) u_try_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (try_clr),
    .inc   (try_inc),
    .cnt   (try_cnt)
  );

  cfl_word_packer #(.SYNC_HI(8'hFF), .SYNC_LO(8'h20)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (pk_clear),
    .take     (take),
    .phase    (phase),
    .din      (s_data),
    .sync_hit (sync_hit),
    .word     (word)
  );

  // outputs
  assign bus_reset = (state_q == ST_RST_HI);
  assign reload    = (state_q == ST_RLD_HI);
  assign prog      = (state_q == ST_PRG_HI);
  assign wr_en     = (state_q == ST_WRITE);
  assign wr_data   = word;
  assign done      = (state_q == ST_DONE);
  assign fail      = (state_q == ST_FAIL);

  AST_CTRL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_reset, reload, prog, wr_en})); // R2

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail); // R1

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (try_cnt <= TRY_LAST)); // R8

  AST_NO_TAKE_IN_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !(bus_reset || reload || prog || wr_en)); // R11

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bus_reset) |=> (bus_reset || state_q == ST_RST_LO)); // R12

endmodule

// File: tb/sim_cfg_stream_loader.sv
`timescale 1ns/1ps
module sim_cfg_stream_loader;

  localparam int S  = 3;
  localparam int G  = 2;
  localparam int P  = 5;
  localparam int GP = 2;
  localparam int T  = 3;
  localparam int INIT_DLY = 3;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        store_present;
  logic [7:0]  s_data;
  logic        s_valid;
  logic        s_last;
  logic        s_ready;
  logic        dev_init;
  logic        bus_reset, reload, prog;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        done, fail;

  int n_checks;
  int n_fails;

  cfg_stream_loader #(
    .SETTLE_CYC(S), .POLL_GAP_CYC(G), .POLL_MAX(P), .GAP_CYC(GP), .MAX_TRY(T)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .store_present(store_present),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .dev_init(dev_init), .bus_reset(bus_reset), .reload(reload), .prog(prog),
    .wr_en(wr_en), .wr_data(wr_data), .done(done), .fail(fail)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stream source
  logic [7:0] src [0:31];
  int src_len;
  int idx;
  bit bubbles;
  int bcyc;

  assign s_valid = (idx < src_len) && (!bubbles || (bcyc % 3 != 1));
  assign s_data  = (idx < src_len) ? src[idx] : 8'h00;
  assign s_last  = (idx == src_len - 1);

  always @(posedge clk) begin
    bcyc <= bcyc + 1;
    if (prog) idx <= 0;
    else if (s_valid && s_ready) idx <= idx + 1;
  end

  // device model
  int n_prog;
  int noinit_tries, drop_tries, drop_after;
  int cd, wcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_init <= 1'b0; cd <= 0; wcnt <= 0;
    end else if (prog) begin
      dev_init <= 1'b0; cd <= INIT_DLY; wcnt <= 0;
    end else if (cd > 0) begin
      cd <= cd - 1;
      if (cd == 1 && n_prog > noinit_tries) dev_init <= 1'b1;
    end else if (wr_en) begin
      wcnt <= wcnt + 1;
      if (n_prog <= drop_tries && wcnt + 1 == drop_after) dev_init <= 1'b0;
    end
  end

  // monitor
  int since_take;
  always @(posedge clk) begin
    if (s_valid && s_ready) since_take <= 0;
    else since_take <= since_take + 1;
  end

  int ncyc, n_brst, n_rld, tot_wr, wr_att;
  logic [15:0] att_words [0:15];
  int w_brst, w_rld, w_prog;
  bit p_brst, p_rld, p_prog, p_wr;
  bit chk_poll, have_pfall;
  int last_prog_hi;

  always @(negedge clk) begin
    if (rst_n) begin
      ncyc++;
      if (bus_reset) w_brst++;
      if (reload)    w_rld++;
      if (prog)      w_prog++;
      if (bus_reset && !p_brst) begin
        n_brst++;
        if (chk_poll && have_pfall) begin
          check(ncyc - last_prog_hi == S + P*G + 1, "R3", "poll window",
                ncyc - last_prog_hi, S + P*G + 1);
          have_pfall = 0;
        end
      end
      if (reload && !p_rld) n_rld++;
      if (prog && !p_prog) begin n_prog++; wr_att = 0; end
      if (!bus_reset && p_brst) begin
        check(w_brst == S, "R2", "reset width", w_brst, S); w_brst = 0;
      end
      if (!reload && p_rld) begin
        check(w_rld == S, "R2", "reload width", w_rld, S); w_rld = 0;
      end
      if (!prog && p_prog) begin
        check(w_prog == S, "R2", "prog width", w_prog, S); w_prog = 0;
        last_prog_hi = ncyc - 1; have_pfall = 1;
      end
      if (wr_en) begin
        check(!p_wr, "R6", "back-to-back write", 1, 0);
        check(since_take == GP, "R6", "gap before write", since_take, GP);
        if (wr_att < 16) att_words[wr_att] = wr_data;
        wr_att++; tot_wr++;
      end
      p_brst = bus_reset; p_rld = reload; p_prog = prog; p_wr = wr_en;
    end
  end

  task automatic put(input logic [7:0] b);
    src[src_len] = b; src_len++;
  endtask

  // expected outcome computed from the requirements
  task automatic predict(input bit store, output bit ok, output int tries,
                         output int last_w, output int total_w, output int si);
    bit has_sync; int full; bit odd;
    has_sync = 0; si = 0; ok = 0; tries = 0; last_w = 0; total_w = 0;
    for (int i = 0; i + 1 < src_len; i++)
      if (!has_sync && src[i] == 8'hFF && src[i+1] == 8'h20) begin
        has_sync = 1; si = i;
      end
    full = has_sync ? (src_len - si) / 2 : 0;
    odd  = has_sync && ((src_len - si) % 2 == 1);
    if (!store) return;
    for (int k = 0; k < T; k++) begin
      int w;
      tries = k + 1;
      if (k < noinit_tries || !has_sync) w = 0;
      else if (k < drop_tries && drop_after <= full) w = drop_after;
      else begin w = full; ok = !odd; end
      total_w += w; last_w = w;
      if (ok) break;
    end
  endtask

  task automatic run(input string name, input bit store, input int noinit,
                     input int dtries, input int dafter, input bit bub,
                     input bit extra_start);
    bit exp_ok; int exp_tries, exp_last, exp_tot, si;
    bit got_done; int wait_c;
    store_present = store; noinit_tries = noinit; drop_tries = dtries;
    drop_after = dafter; bubbles = bub;
    n_prog = 0; n_brst = 0; n_rld = 0; tot_wr = 0; wr_att = 0; have_pfall = 0;
    predict(store, exp_ok, exp_tries, exp_last, exp_tot, si);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!fail, "R1", {name, " fail cleared by start"}, fail, 0);
    if (extra_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    got_done = 0; wait_c = 0;
    while (!got_done && !fail && wait_c < 20000) begin
      @(negedge clk); wait_c++;
      if (done) got_done = 1;
    end
    check(wait_c < 20000, "R8", {name, " run finished"}, wait_c, 0);
    repeat (3) @(negedge clk);
    check(done == 0, "R9", {name, " done single cycle"}, done, 0);
    check(got_done == exp_ok, "R9", {name, " done outcome"}, got_done, exp_ok);
    check(fail == !exp_ok, "R8", {name, " fail outcome"}, fail, !exp_ok);
    check(n_prog == exp_tries, "R8", {name, " program pulses"}, n_prog, exp_tries);
    check(n_brst == exp_tries + exp_ok, "R9", {name, " reset pulses"}, n_brst, exp_tries + exp_ok);
    check(n_rld == exp_tries + exp_ok, "R2", {name, " reload pulses"}, n_rld, exp_tries + exp_ok);
    check(tot_wr == exp_tot, "R7", {name, " total writes"}, tot_wr, exp_tot);
    check(wr_att == exp_last, "R10", {name, " last attempt writes"}, wr_att, exp_last);
    for (int j = 0; j < wr_att && j < 16; j++) begin
      logic [15:0] ew;
      ew = {src[si + 2*j], src[si + 2*j + 1]};
      check(att_words[j] == ew, (j == 0) ? "R4" : "R5", {name, " word"}, att_words[j], ew);
    end
    check(!s_ready, "R11", {name, " ready low after run"}, s_ready, 0);
  endtask

  initial begin
    n_checks = 0; n_fails = 0;
    rst_n = 1'b0; start = 1'b0; store_present = 1'b0;
    src_len = 0; bubbles = 0; noinit_tries = 0; drop_tries = 0; drop_after = 0;
    n_prog = 0; chk_poll = 0;
    repeat (4) @(negedge clk);
    check({s_ready, bus_reset, reload, prog, wr_en, done, fail} == 7'b0, "R11",
          "reset state", {s_ready, bus_reset, reload, prog, wr_en, done, fail}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // store absent
    put(8'hFF); put(8'h20); put(8'h12); put(8'h34);
    run("absent", 0, 0, 0, 0, 0, 0);
    check(idx == 0, "R11", "no byte taken without store", idx, 0);
    check(n_brst == 0 && n_prog == 0, "R1", "no control pulses", n_brst + n_prog, 0);
    repeat (10) @(negedge clk);
    check(fail, "R1", "fail sticky", fail, 1);

    // normal load with tricky header
    src_len = 0;
    put(8'h11); put(8'hFF); put(8'h00); put(8'hFF); put(8'hFF); put(8'h20);
    put(8'hA5); put(8'h5A); put(8'h01); put(8'h02); put(8'hC3); put(8'h3C);
    run("normal", 1, 0, 0, 0, 0, 0);
    run("bubbles", 1, 0, 0, 0, 1, 0);
    run("late init", 1, 1, 0, 0, 0, 0);
    chk_poll = 1;
    run("no init", 1, 3, 0, 0, 0, 0);
    chk_poll = 0;
    run("drop all", 1, 0, 3, 2, 0, 0);
    run("drop once", 1, 0, 1, 3, 1, 0);
    run("busy start", 1, 0, 0, 0, 0, 1);

    // half pair at end (R10)
    src_len = 0;
    put(8'h00); put(8'hFF); put(8'h20); put(8'h12); put(8'h34); put(8'h56);
    run("half pair", 1, 0, 0, 0, 0, 0);

    // no marker (R10)
    src_len = 0;
    put(8'hFF); put(8'h00); put(8'h20); put(8'hFF); put(8'hFF);
    run("no sync", 1, 0, 0, 0, 0, 0);

    // marker ends the stream (R4, R9)
    src_len = 0;
    put(8'h7E); put(8'hFF); put(8'h20);
    run("sync last", 1, 0, 0, 0, 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL R8 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule